// File: doc/BRIEF.md
# Multi-source Maskable Interrupt Controller

This block merges three kinds of interrupt request into one pending indication for a processor's exception logic. The first kind is a set of level-sensitive request pins. The second is a register of request bits that software sets and clears. The third is a register of asynchronous trap requests, with one bit for each processor mode. Each request bit has its own enable bit. Software therefore sets up a priority scheme by choosing which enable patterns it writes. For example, it can enable a shrinking group of pins to raise the effective priority level.

Trap requests pass two further checks. A trap bit belonging to a less privileged mode is blocked while the processor runs in a more privileged mode. All trap bits are also gated by one global trap-enable bit. The pending output is held low while the processor runs privileged firmware. Saving state, draining and vectoring are left to the processor. Software reaches every register through a simple register port with a write strobe, an address and a registered read-data output. The hardware request register is a live view of the synchronized pins and holds no latched copy.

Top module: `intc_core`

## Requirements
- R1: After synchronous reset, every software request, trap request and enable register reads zero, irq_pending_o is 0 and reg_rdata_o is 0.
- R2: Address 0 reads the hardware request register, which is read-only. Bits [NUM_HW-1:0] show the pin levels after a two-flop synchronizer and reg_rdata_o is registered, so a pin change appears in the read data three clock edges later. A request removed before the read returns zero, and writes to address 0 have no effect.
- R3: Address 1 holds the software request register: bits [14:0] can be read and written, and bit 15 always reads 0.
- R4: Address 2 holds the trap request register, with bit m (m = 0..3) belonging to processor mode m. Addresses 3, 4 and 5 hold the enables for pins, software requests and traps, each at the same bit positions as its requests. Address 6 bit 0 is the global trap enable. Address 7 reads 0.
- R5: A pin or software request contributes to the pending output only while its own enable bit is set.
- R6: Trap bit m contributes only when its request and enable bits are set, the global trap enable is 1, and mode_i >= m. Mode 0 is the most privileged mode.
- R7: While priv_i is 1, irq_pending_o is 0 whatever the requests are.
- R8: irq_pending_o is registered. It reflects a register write one edge after the storing edge, a mode_i or priv_i change one edge later, and a pin change three edges later.
- R9: With all pin enable bits cleared, no pin pattern raises irq_pending_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hw_irq_i | input | NUM_HW | Level-sensitive request pins (asynchronous) |
| mode_i | input | MODE_W | Current processor mode, 0 most privileged |
| priv_i | input | 1 | Processor is running privileged firmware; holds off delivery |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address for read and write |
| reg_wdata_i | input | REG_W | Register write data |
| reg_rdata_o | output | REG_W | Registered read data for reg_addr_i |
| irq_pending_o | output | 1 | Registered interrupt-pending indication |

## Verification
The bench builds the block with its default sizes: six pins, fifteen software bits and four modes. This makes every pin pattern sweepable under several enable masks. Every combination of trap request and trap enable is visited in every mode, with both global-enable values and both privileged-mode values. Each software bit is walked one at a time against full, empty and alternating enable masks. The small sizes also let the bench count the exact edge at which the pending output responds to a pin, a register write and a mode change.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int REG_W  = 16;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_HWREQ  = 3'd0,
    A_SWREQ  = 3'd1,
    A_TRPREQ = 3'd2,
    A_HWEN   = 3'd3,
    A_SWEN   = 3'd4,
    A_TRPEN  = 3'd5,
    A_GLBEN  = 3'd6,
    A_NONE   = 3'd7
  } reg_addr_e;
endpackage

// File: rtl/intc_sync.sv
module intc_sync #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] stage1_q;
  logic [W-1:0] stage2_q;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) begin
        stage1_q[i] <= 1'b0;
        stage2_q[i] <= 1'b0;
      end else begin
        stage1_q[i] <= async_i[i];
        stage2_q[i] <= stage1_q[i];
      end
    end
  end

  assign sync_o = stage2_q;
endmodule

// File: rtl/intc_regs.sv
module intc_regs
  import intc_pkg::*;
#(
  parameter int NUM_HW    = 6,
  parameter int NUM_SW    = 15,
  parameter int NUM_MODES = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [REG_W-1:0]     wdata_i,
  input  logic [NUM_HW-1:0]    hw_req_i,
  output logic [REG_W-1:0]     rdata_o,
  output logic [NUM_SW-1:0]    sw_req_o,
  output logic [NUM_MODES-1:0] trp_req_o,
  output logic [NUM_HW-1:0]    hw_en_o,
  output logic [NUM_SW-1:0]    sw_en_o,
  output logic [NUM_MODES-1:0] trp_en_o,
  output logic                 glb_en_o
);
  logic [NUM_SW-1:0]    sw_req_q, sw_en_q;
  logic [NUM_MODES-1:0] trp_req_q, trp_en_q;
  logic [NUM_HW-1:0]    hw_en_q;
  logic                 glb_en_q;
  logic [REG_W-1:0]     rdata_d, rdata_q;
  reg_addr_e            sel;
  logic                 unused_wdata;

  assign sel          = reg_addr_e'(addr_i);
  assign unused_wdata = ^wdata_i[REG_W-1:NUM_SW];

  always_ff @(posedge clk) begin
    if (rst) begin
      sw_req_q  <= '0;
      sw_en_q   <= '0;
      trp_req_q <= '0;
      trp_en_q  <= '0;
      hw_en_q   <= '0;
      glb_en_q  <= 1'b0;
    end else if (wr_i) begin
      case (sel)
        A_SWREQ:  sw_req_q  <= wdata_i[NUM_SW-1:0];
        A_TRPREQ: trp_req_q <= wdata_i[NUM_MODES-1:0];
        A_HWEN:   hw_en_q   <= wdata_i[NUM_HW-1:0];
        A_SWEN:   sw_en_q   <= wdata_i[NUM_SW-1:0];
        A_TRPEN:  trp_en_q  <= wdata_i[NUM_MODES-1:0];
        A_GLBEN:  glb_en_q  <= wdata_i[0];
        default:  ;
      endcase
    end
  end

  always_comb begin
    rdata_d = '0;
    case (sel)
      A_HWREQ:  rdata_d[NUM_HW-1:0]    = hw_req_i;
      A_SWREQ:  rdata_d[NUM_SW-1:0]    = sw_req_q;
      A_TRPREQ: rdata_d[NUM_MODES-1:0] = trp_req_q;
      A_HWEN:   rdata_d[NUM_HW-1:0]    = hw_en_q;
      A_SWEN:   rdata_d[NUM_SW-1:0]    = sw_en_q;
      A_TRPEN:  rdata_d[NUM_MODES-1:0] = trp_en_q;
      A_GLBEN:  rdata_d[0]             = glb_en_q;
      default:  rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= rdata_d;
  end

  assign rdata_o   = rdata_q;
  assign sw_req_o  = sw_req_q;
  assign trp_req_o = trp_req_q;
  assign hw_en_o   = hw_en_q;
  assign sw_en_o   = sw_en_q;
  assign trp_en_o  = trp_en_q;
  assign glb_en_o  = glb_en_q;
endmodule

// File: rtl/intc_trap_qual.sv
module intc_trap_qual #(
  parameter int NUM_MODES = 4,
  localparam int MODE_W   = $clog2(NUM_MODES)
) (
  input  logic [NUM_MODES-1:0] req_i,
  input  logic [NUM_MODES-1:0] en_i,
  input  logic                 glb_en_i,
  input  logic [MODE_W-1:0]    mode_i,
  output logic [NUM_MODES-1:0] live_o
);
  for (genvar m = 0; m < NUM_MODES; m++) begin : g_mode
    logic mode_ok;
    assign mode_ok   = (mode_i >= MODE_W'(m));
    assign live_o[m] = req_i[m] & en_i[m] & mode_ok & glb_en_i;
  end
endmodule

// File: rtl/intc_pend.sv
module intc_pend #(
  parameter int NUM_HW    = 6,
  parameter int NUM_SW    = 15,
  parameter int NUM_MODES = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_HW-1:0]    hw_req_i,
  input  logic [NUM_HW-1:0]    hw_en_i,
  input  logic [NUM_SW-1:0]    sw_req_i,
  input  logic [NUM_SW-1:0]    sw_en_i,
  input  logic [NUM_MODES-1:0] trp_live_i,
  input  logic                 priv_i,
  output logic                 pend_o
);
  logic any_hw, any_sw, any_trp, pend_q;

  assign any_hw  = |(hw_req_i & hw_en_i);
  assign any_sw  = |(sw_req_i & sw_en_i);
  assign any_trp = |trp_live_i;

  always_ff @(posedge clk) begin
    if (rst) pend_q <= 1'b0;
    else     pend_q <= (any_hw | any_sw | any_trp) & ~priv_i;
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/intc_core.sv
module intc_core
  import intc_pkg::*;
#(
  parameter int NUM_HW    = 6,
  parameter int NUM_SW    = 15,
  parameter int NUM_MODES = 4,
  localparam int MODE_W   = $clog2(NUM_MODES)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_HW-1:0]    hw_irq_i,
  input  logic [MODE_W-1:0]    mode_i,
  input  logic                 priv_i,
  input  logic                 reg_wr_i,
  input  logic [ADDR_W-1:0]    reg_addr_i,
  input  logic [REG_W-1:0]     reg_wdata_i,
  output logic [REG_W-1:0]     reg_rdata_o,
  output logic                 irq_pending_o
);
  logic [NUM_HW-1:0]    hw_req;
  logic [NUM_HW-1:0]    hw_en;
  logic [NUM_SW-1:0]    sw_req, sw_en;
  logic [NUM_MODES-1:0] trp_req, trp_en, trp_live;
  logic                 glb_en;

  intc_sync #(.W(NUM_HW)) u_sync (
    .clk(clk), .rst(rst), .async_i(hw_irq_i), .sync_o(hw_req)
  );

  intc_regs #(.NUM_HW(NUM_HW), .NUM_SW(NUM_SW), .NUM_MODES(NUM_MODES)) u_regs (
    .clk(clk), .rst(rst), .wr_i(reg_wr_i), .addr_i(reg_addr_i),
    .wdata_i(reg_wdata_i), .hw_req_i(hw_req), .rdata_o(reg_rdata_o),
    .sw_req_o(sw_req), .trp_req_o(trp_req), .hw_en_o(hw_en),
    .sw_en_o(sw_en), .trp_en_o(trp_en), .glb_en_o(glb_en)
  );

  intc_trap_qual #(.NUM_MODES(NUM_MODES)) u_trap (
    .req_i(trp_req), .en_i(trp_en), .glb_en_i(glb_en),
    .mode_i(mode_i), .live_o(trp_live)
  );

  intc_pend #(.NUM_HW(NUM_HW), .NUM_SW(NUM_SW), .NUM_MODES(NUM_MODES)) u_pend (
    .clk(clk), .rst(rst), .hw_req_i(hw_req), .hw_en_i(hw_en),
    .sw_req_i(sw_req), .sw_en_i(sw_en), .trp_live_i(trp_live),
    .priv_i(priv_i), .pend_o(irq_pending_o)
  );
endmodule

// File: rtl/intc_core_chk.sv
module intc_core_chk #(
  parameter int NUM_HW    = 6,
  parameter int NUM_SW    = 15,
  parameter int NUM_MODES = 4,
  parameter int REG_W     = 16
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 priv_i,
  input logic [NUM_HW-1:0]    hw_en,
  input logic [NUM_SW-1:0]    sw_en,
  input logic [NUM_SW-1:0]    sw_req,
  input logic                 glb_en,
  input logic [REG_W-1:0]     reg_rdata_o,
  input logic                 irq_pending_o
);
  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (!irq_pending_o && reg_rdata_o == '0)); // R1

  AST_PRIV_HOLDOFF: assert property (@(posedge clk) disable iff (rst)
    priv_i |=> !irq_pending_o); // R7

  AST_NO_SOURCE_NO_PEND: assert property (@(posedge clk) disable iff (rst)
    (hw_en == '0 && sw_en == '0 && !glb_en) |=> !irq_pending_o); // R9

  AST_SW_ONLY_ENABLED: assert property (@(posedge clk) disable iff (rst)
    (hw_en == '0 && !glb_en && (sw_req & sw_en) != '0 && !priv_i) |=> irq_pending_o); // R5

  AST_TOP_BIT_ZERO: assert property (@(posedge clk) disable iff (rst)
    !reg_rdata_o[REG_W-1]); // R3
endmodule

bind intc_core intc_core_chk #(
  .NUM_HW(NUM_HW), .NUM_SW(NUM_SW), .NUM_MODES(NUM_MODES), .REG_W(intc_pkg::REG_W)
) u_chk (
  .clk(clk), .rst(rst), .priv_i(priv_i), .hw_en(hw_en), .sw_en(sw_en),
  .sw_req(sw_req), .glb_en(glb_en), .reg_rdata_o(reg_rdata_o),
  .irq_pending_o(irq_pending_o)
);

// File: tb/sim_intc_core.sv
module sim_intc_core;
  localparam int NHW = 6;
  localparam int NSW = 15;
  localparam int NMD = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [5:0]  hw_irq = '0;
  logic [1:0]  mode = 2'd3;
  logic        priv = 1'b0;
  logic        wr = 1'b0;
  logic [2:0]  addr = 3'd0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        pend;

  int n_chk  = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  intc_core #(.NUM_HW(NHW), .NUM_SW(NSW), .NUM_MODES(NMD)) u0 (
    .clk(clk), .rst(rst), .hw_irq_i(hw_irq), .mode_i(mode), .priv_i(priv),
    .reg_wr_i(wr), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_pending_o(pend)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // Called at a negedge; returns at the next negedge, after the storing edge.
  task automatic wreg(input logic [2:0] a, input logic [15:0] d);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rreg(input logic [2:0] a, output logic [15:0] d);
    addr = a;
    @(negedge clk);
    d = rdata;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [15:0] rd;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 pending", {15'd0, pend}, 16'd0);
    chk("R1 rdata", rdata, 16'd0);
    for (int a = 1; a < 8; a++) begin
      rreg(3'(a), rd);
      chk("R1 register", rd, 16'd0);
    end

    // R3 / R4 register widths and unused address
    wreg(3'd1, 16'hFFFF); rreg(3'd1, rd); chk("R3 sw width", rd, 16'h7FFF);
    wreg(3'd1, 16'h0000);
    wreg(3'd2, 16'hFFFF); rreg(3'd2, rd); chk("R4 trap width", rd, 16'h000F);
    wreg(3'd2, 16'h0000);
    wreg(3'd3, 16'hFFFF); rreg(3'd3, rd); chk("R4 hw enable width", rd, 16'h003F);
    wreg(3'd5, 16'hFFFF); rreg(3'd5, rd); chk("R4 trap enable width", rd, 16'h000F);
    wreg(3'd6, 16'hFFFF); rreg(3'd6, rd); chk("R4 global enable width", rd, 16'h0001);
    wreg(3'd7, 16'hFFFF); rreg(3'd7, rd); chk("R4 addr7 reads zero", rd, 16'h0000);
    wreg(3'd5, 16'h0000); wreg(3'd6, 16'h0000);
    // R2 writes to address 0 ignored
    wreg(3'd0, 16'hFFFF); rreg(3'd0, rd); chk("R2 read-only", rd, 16'h0000);

    // R8 pin latency: hw enable all set
    addr = 3'd0;
    hw_irq = 6'h01;
    @(negedge clk); @(negedge clk);
    chk("R8 pin not yet", {15'd0, pend}, 16'd0);
    @(negedge clk);
    chk("R8 pin third edge", {15'd0, pend}, 16'd1);
    chk("R2 pin read third edge", rdata, 16'h0001);
    hw_irq = 6'h00;
    repeat (3) @(negedge clk);
    chk("R2 removed request reads zero", rdata, 16'h0000);
    // R7 priv hold-off on pins
    hw_irq = 6'h3F; priv = 1'b1;
    repeat (3) @(negedge clk);
    chk("R7 priv holds off", {15'd0, pend}, 16'd0);
    priv = 1'b0;
    @(negedge clk);
    chk("R8 priv release one edge", {15'd0, pend}, 16'd1);
    hw_irq = 6'h00;

    // R2 / R5 / R9 pin sweep under several enable masks
    for (int e = 0; e < 4; e++) begin
      logic [5:0] en;
      en = (e == 0) ? 6'h3F : (e == 1) ? 6'h00 : (e == 2) ? 6'h2A : 6'h20;
      wreg(3'd3, {10'd0, en});
      addr = 3'd0;
      for (int p = 0; p < 64; p++) begin
        hw_irq = 6'(p);
        repeat (3) @(negedge clk);
        chk("R2 pin view", rdata, 16'(p));
        if (en == 6'h00) chk("R9 pins masked", {15'd0, pend}, 16'd0);
        else             chk("R5 pin enable", {15'd0, pend}, {15'd0, |(6'(p) & en)});
      end
    end
    hw_irq = 6'h00;
    wreg(3'd3, 16'h0000);
    repeat (3) @(negedge clk);

    // R8 register-write latency
    wreg(3'd4, 16'h0001);
    addr = 3'd1; wdata = 16'h0001; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
    chk("R8 write not yet", {15'd0, pend}, 16'd0);
    @(negedge clk);
    chk("R8 write one edge later", {15'd0, pend}, 16'd1);
    wreg(3'd1, 16'h0000);

    // R3 / R5 software walk
    for (int e = 0; e < 3; e++) begin
      logic [14:0] sen;
      sen = (e == 0) ? 15'h7FFF : (e == 1) ? 15'h0000 : 15'h5555;
      wreg(3'd4, {1'b0, sen});
      for (int b = 0; b < 15; b++) begin
        wreg(3'd1, 16'(1 << b));
        @(negedge clk);
        chk("R5 sw enable", {15'd0, pend}, {15'd0, sen[b]});
        rreg(3'd1, rd);
        chk("R3 sw readback", rd, 16'(1 << b));
      end
    end
    wreg(3'd1, 16'h0000); wreg(3'd4, 16'h0000);
    @(negedge clk);

    // R6 / R7 exhaustive trap sweep
    for (int rq = 0; rq < 16; rq++) begin
      for (int en = 0; en < 16; en++) begin
        wreg(3'd2, 16'(rq));
        wreg(3'd5, 16'(en));
        for (int g = 0; g < 2; g++) begin
          wreg(3'd6, 16'(g));
          for (int m = 0; m < 4; m++) begin
            for (int p = 0; p < 2; p++) begin
              logic e;
              mode = 2'(m); priv = 1'(p);
              @(negedge clk);
              e = 1'b0;
              for (int k = 0; k < 4; k++)
                if (rq[k] && en[k] && m >= k) e = 1'b1;
              e = e & (g == 1) & (p == 0);
              if (p == 1) chk("R7 trap priv", {15'd0, pend}, 16'd0);
              else        chk("R6 trap qualify", {15'd0, pend}, {15'd0, e});
            end
          end
        end
      end
    end
    priv = 1'b0; mode = 2'd3;

    // R8 mode-change latency: trap for mode 3 only
    wreg(3'd2, 16'h0008); wreg(3'd5, 16'h0008); wreg(3'd6, 16'h0001);
    mode = 2'd3;
    @(negedge clk);
    chk("R8 mode 3 pend", {15'd0, pend}, 16'd1);
    mode = 2'd2;
    @(negedge clk);
    chk("R8 mode change one edge", {15'd0, pend}, 16'd0);

    summary();
  end
endmodule